// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block manages the low-power sleep state of a small processor core. When the core executes its sleep instruction it raises a one-cycle strobe. The controller then freezes the core and clears the power-down status bit. The core stays frozen until one of three things happens: a watchdog time-out, an interrupt source whose own enable is set, or an external reset. Instruction fetch, the watchdog counter, the interrupt flag registers and the oscillator are outside the block and appear only as ports.

A watchdog or interrupt wake does not reset the core. The controller first holds the core for an oscillator start-up delay. The delay is long in crystal mode and short in RC mode, and a parameter selects the mode. The controller then releases the core for one instruction cycle, which executes the already prefetched instruction after the sleep. If the global interrupt enable was set at the wake, it then issues a one-cycle vector request together with a bubble indication, so the core inserts a dummy cycle and fetches from the interrupt address. If the global enable was clear, execution simply continues in line. Every wake pulses a watchdog clear.

The global enable never blocks a wake. If an enabled interrupt is already pending when the sleep strobe arrives, the sleep instruction still completes and clears the power-down bit, but the core is not frozen and there is no start-up delay. An external reset overrides every other input in every state.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: A sleep strobe in the run state with no enabled interrupt pending asserts core_freeze and clears pd_bit from the next cycle on.
- R2: While sleeping, interrupt flags whose enable bit is 0, and any change of gie, leave core_freeze asserted.
- R3: During sleep, any bit position i with irq_flags[i]=1 and irq_enables[i]=1 starts a wake, whatever the value of gie.
- R4: A watchdog time-out during sleep starts a wake and clears to_bit. An interrupt wake leaves to_bit unchanged.
- R5: Every wake (watchdog, interrupt or immediate) raises wdt_clear for exactly one cycle, in the cycle after the wake event.
- R6: After a wake from sleep, core_freeze stays asserted for exactly XTAL_DELAY cycles when OSC_MODE=0 and RC_DELAY cycles when OSC_MODE=1, counted from the cycle after the wake event.
- R7: After the release, one cycle passes with vector_req=0. In the next cycle vector_req and bubble are both 1 for one cycle if gie was 1 at the wake event, and they stay 0 if gie was 0. Later changes of gie have no effect.
- R8: A sleep strobe while an enabled interrupt is pending clears pd_bit and pulses wdt_clear, but never asserts core_freeze. The R7 sequence then follows at once.
- R9: ext_rst in any state returns the controller to run from the next cycle: core_freeze=0, pd_bit=1, to_bit=1, no wdt_clear and no vector. It takes priority over a simultaneous watchdog or interrupt wake.
- R10: After power-on reset, core_freeze=0, wdt_clear=0, vector_req=0, bubble=0, pd_bit=1 and to_bit=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | Synchronous external reset request |
| sleep_strobe | input | 1 | One-cycle pulse when the sleep instruction executes |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| gie | input | 1 | Global interrupt enable from the core |
| irq_flags | input | NUM_IRQ | Interrupt flag bits |
| irq_enables | input | NUM_IRQ | Per-source interrupt enable bits |
| core_freeze | output | 1 | Holds the core halted |
| wdt_clear | output | 1 | One-cycle watchdog clear pulse |
| vector_req | output | 1 | Requests a branch to the interrupt address |
| bubble | output | 1 | Asks the core to insert a dummy cycle |
| to_bit | output | 1 | Time-out status, 0 after a watchdog wake |
| pd_bit | output | 1 | Power-down status, 0 after a sleep instruction |

## Verification
The bench wakes the controller from every interrupt position and from the watchdog, once with gie clear and once with gie set. It flips gie right after each wake, so a design that samples gie at release time vectors on the wrong cycles. It counts frozen cycles on a crystal-mode and an RC-mode instance at the same time, which exposes an off-by-one start-up counter or a swapped mode. Disabled flags are held high during sleep, so a wake term that ignores the enables releases the core early. A pending interrupt at the sleep strobe tests the immediate-wake path, and external resets are applied during sleep together with a wake source and again partway through the start-up delay, where a reset with the wrong priority leaves the core frozen or lets a vector through.

// File: rtl/swc_pkg.sv
package swc_pkg;
   localparam int OSC_XTAL = 0;
   localparam int OSC_RC   = 1;

   typedef enum logic [2:0] {
      ST_RUN,
      ST_SLEEP,
      ST_STARTUP,
      ST_RESUME,
      ST_VECTOR
   } swc_state_e;
endpackage

// File: rtl/swc_irq_detect.sv
module swc_irq_detect #(
   parameter int NUM_IRQ = 4
) (
   input  logic [NUM_IRQ-1:0] flags,
   input  logic [NUM_IRQ-1:0] enables,
   output logic               pending
);
   logic [NUM_IRQ-1:0] armed;

   genvar i;
   generate
      for (i = 0; i < NUM_IRQ; i++) begin : g_src
         assign armed[i] = flags[i] & enables[i];
      end
   endgenerate

   assign pending = |armed;
endmodule

// File: rtl/swc_startup_timer.sv
module swc_startup_timer #(
   parameter int OSC_MODE   = 0,
   parameter int XTAL_DELAY = 1024,
   parameter int RC_DELAY   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);
   import swc_pkg::*;

   localparam int DELAY = (OSC_MODE == OSC_RC) ? RC_DELAY : XTAL_DELAY;
   localparam int CW    = (DELAY > 1) ? $clog2(DELAY) : 1;

   generate
      if (DELAY == 1) begin : g_single
         assign done = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= CW'(DELAY - 1);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign done = (cnt_q == '0);

         // R6
         count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !load) |=> done);
      end
   endgenerate
endmodule

// File: rtl/swc_status_bits.sv
module swc_status_bits (
   input  logic clk,
   input  logic rst_n,
   input  logic set_all,
   input  logic clr_pd,
   input  logic clr_to,
   output logic pd_bit,
   output logic to_bit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_bit <= 1'b1;
         to_bit <= 1'b1;
      end else if (set_all) begin
         pd_bit <= 1'b1;
         to_bit <= 1'b1;
      end else begin
         if (clr_pd) pd_bit <= 1'b0;
         if (clr_to) to_bit <= 1'b0;
      end
   end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
   parameter int NUM_IRQ    = 4,
   parameter int OSC_MODE   = 0,
   parameter int XTAL_DELAY = 1024,
   parameter int RC_DELAY   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext_rst,
   input  logic               sleep_strobe,
   input  logic               wdt_timeout,
   input  logic               gie,
   input  logic [NUM_IRQ-1:0] irq_flags,
   input  logic [NUM_IRQ-1:0] irq_enables,
   output logic               core_freeze,
   output logic               wdt_clear,
   output logic               vector_req,
   output logic               bubble,
   output logic               to_bit,
   output logic               pd_bit
);
   import swc_pkg::*;

   generate
      if (NUM_IRQ < 1) begin : g_bad_irq
         $error("NUM_IRQ must be at least 1");
      end
      if (OSC_MODE != OSC_XTAL && OSC_MODE != OSC_RC) begin : g_bad_mode
         $error("OSC_MODE must be 0 or 1");
      end
      if (XTAL_DELAY < 1 || RC_DELAY < 1) begin : g_bad_delay
         $error("start-up delays must be at least 1");
      end
   endgenerate

   swc_state_e st_q, st_d;
   logic pending, timer_done, timer_load;
   logic wake, clr_pd, clr_to, latch_gie;
   logic gie_q, wclr_q;

   swc_irq_detect #(.NUM_IRQ(NUM_IRQ)) u_irq (
      .flags   (irq_flags),
      .enables (irq_enables),
      .pending (pending)
   );

   swc_startup_timer #(
      .OSC_MODE   (OSC_MODE),
      .XTAL_DELAY (XTAL_DELAY),
      .RC_DELAY   (RC_DELAY)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (timer_load),
      .done  (timer_done)
   );

   swc_status_bits u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_all (ext_rst),
      .clr_pd  (clr_pd),
      .clr_to  (clr_to),
      .pd_bit  (pd_bit),
      .to_bit  (to_bit)
   );

   always_comb begin
      st_d       = st_q;
      timer_load = 1'b0;
      wake       = 1'b0;
      clr_pd     = 1'b0;
      clr_to     = 1'b0;
      latch_gie  = 1'b0;
      if (ext_rst) begin
         st_d = ST_RUN;
      end else begin
         unique case (st_q)
            ST_RUN: begin
               if (sleep_strobe) begin
                  clr_pd = 1'b1;
                  if (pending) begin
                     st_d      = ST_RESUME;
                     wake      = 1'b1;
                     latch_gie = 1'b1;
                  end else begin
                     st_d = ST_SLEEP;
                  end
               end
            end
            ST_SLEEP: begin
               if (wdt_timeout || pending) begin
                  st_d       = ST_STARTUP;
                  timer_load = 1'b1;
                  wake       = 1'b1;
                  latch_gie  = 1'b1;
                  clr_to     = wdt_timeout;
               end
            end
            ST_STARTUP: begin
               if (timer_done) st_d = ST_RESUME;
            end
            ST_RESUME: st_d = gie_q ? ST_VECTOR : ST_RUN;
            ST_VECTOR: st_d = ST_RUN;
            default:   st_d = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         gie_q  <= 1'b0;
         wclr_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         wclr_q <= wake;
         if (latch_gie) gie_q <= gie;
      end
   end

   assign core_freeze = (st_q == ST_SLEEP) || (st_q == ST_STARTUP);
   assign wdt_clear   = wclr_q;
   assign vector_req  = (st_q == ST_VECTOR);
   assign bubble      = (st_q == ST_VECTOR);

   // R1
   sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && sleep_strobe && !pending && !ext_rst) |=> (core_freeze && !pd_bit));

   // R4
   wdt_wake_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SLEEP && wdt_timeout && !ext_rst) |=> (!to_bit && core_freeze));

   // R5
   wdt_clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clear |=> !wdt_clear);

   // R7
   vec_after_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vector_req |-> ($past(st_q == ST_RESUME) && !core_freeze));

   // R9
   ext_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rst |=> (pd_bit && to_bit && !core_freeze && !vector_req && !wdt_clear));
endmodule

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;
   localparam int N  = 4;
   localparam int XD = 1024;
   localparam int RD = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, ext_rst, sleep_strobe, wdt_timeout, gie;
   logic [N-1:0] flags, enables;
   logic x_frz, x_wclr, x_vec, x_bub, x_to, x_pd;
   logic r_frz, r_wclr, r_vec, r_bub, r_to, r_pd;

   sleep_wake_ctrl #(.NUM_IRQ(N), .OSC_MODE(0), .XTAL_DELAY(XD), .RC_DELAY(RD)) u_sleep_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .sleep_strobe(sleep_strobe),
      .wdt_timeout(wdt_timeout), .gie(gie), .irq_flags(flags), .irq_enables(enables),
      .core_freeze(x_frz), .wdt_clear(x_wclr), .vector_req(x_vec), .bubble(x_bub),
      .to_bit(x_to), .pd_bit(x_pd));

   sleep_wake_ctrl #(.NUM_IRQ(N), .OSC_MODE(1), .XTAL_DELAY(XD), .RC_DELAY(RD)) u_rc (
      .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .sleep_strobe(sleep_strobe),
      .wdt_timeout(wdt_timeout), .gie(gie), .irq_flags(flags), .irq_enables(enables),
      .core_freeze(r_frz), .wdt_clear(r_wclr), .vector_req(r_vec), .bubble(r_bub),
      .to_bit(r_to), .pd_bit(r_pd));

   int n_chk  = 0;
   int n_fail = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      bit to_exp;
      rst_n = 1'b0; ext_rst = 1'b0; sleep_strobe = 1'b0; wdt_timeout = 1'b0;
      gie = 1'b0; flags = '0; enables = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R10 reset state
      chk("R10 freeze", int'(x_frz), 0);
      chk("R10 wdt_clear", int'(x_wclr), 0);
      chk("R10 vector", int'(x_vec | x_bub), 0);
      chk("R10 pd", int'(x_pd), 1);
      chk("R10 to", int'(x_to), 1);
      to_exp = 1'b1;

      for (int g = 0; g < 2; g++) begin
         for (int s = 0; s <= N; s++) begin
            int xc, rc, xrel, rrel;
            sleep_strobe = 1'b1;
            tick();
            sleep_strobe = 1'b0;
            chk("R1 freeze", int'(x_frz), 1);
            chk("R1 pd", int'(x_pd), 0);
            // R2 disabled flags and gie toggling do not wake
            flags = '1; enables = '0;
            for (int k = 0; k < 4; k++) begin
               gie = ~gie;
               tick();
            end
            chk("R2 freeze xtal", int'(x_frz), 1);
            chk("R2 freeze rc", int'(r_frz), 1);
            flags = '0;
            gie = (g == 1);
            if (s < N) begin
               flags[s] = 1'b1; enables[s] = 1'b1;   // R3 wake source
            end else begin
               wdt_timeout = 1'b1;                   // R4 wake source
            end
            tick();
            flags = '0; enables = '0; wdt_timeout = 1'b0;
            gie = (g == 0);
            chk("R5 wdt_clear", int'(x_wclr), 1);
            if (s == N) to_exp = 1'b0;
            chk("R4 to", int'(x_to), int'(to_exp));
            xc = 0; rc = 0; xrel = 0; rrel = 0;
            for (int k = 1; k <= XD + 4; k++) begin
               if (k > 1) tick();
               if (k == 2) chk("R5 single pulse", int'(x_wclr), 0);
               if (x_frz) xc++;
               if (r_frz) rc++;
               if (!x_frz && xrel == 0) begin
                  xrel = k;
                  chk("R7 no vector at release", int'(x_vec), 0);
               end else if (xrel != 0 && k == xrel + 1) begin
                  chk("R7 vector xtal", int'(x_vec), g);
                  chk("R7 bubble xtal", int'(x_bub), g);
               end else if (xrel != 0 && k == xrel + 2) begin
                  chk("R7 vector one cycle", int'(x_vec), 0);
               end
               if (!r_frz && rrel == 0) begin
                  rrel = k;
               end else if (rrel != 0 && k == rrel + 1) begin
                  chk("R7 vector rc", int'(r_vec), g);
               end
            end
            chk("R6 xtal delay", xc, XD);
            chk("R6 rc delay", rc, RD);
            chk("R3 woke", int'(xrel != 0), 1);
         end
      end

      // R9 reset restores status, then R8 immediate wake
      ext_rst = 1'b1;
      tick();
      ext_rst = 1'b0;
      chk("R9 pd set", int'(x_pd), 1);
      chk("R9 to set", int'(x_to), 1);
      for (int g = 0; g < 2; g++) begin
         flags = 4'b0100; enables = 4'b0110; gie = (g == 1);
         sleep_strobe = 1'b1;
         tick();
         sleep_strobe = 1'b0; flags = '0; enables = '0; gie = (g == 0);
         chk("R8 no freeze", int'(x_frz | r_frz), 0);
         chk("R8 pd cleared", int'(x_pd), 0);
         chk("R8 wdt_clear", int'(x_wclr), 1);
         tick();
         chk("R8 vector", int'(x_vec), g);
         chk("R8 no freeze later", int'(x_frz), 0);
         tick();
         chk("R8 vector ends", int'(x_vec), 0);
         tick();
      end

      // R9 reset during sleep beats simultaneous wake sources
      sleep_strobe = 1'b1;
      tick();
      sleep_strobe = 1'b0;
      flags = 4'b0001; enables = 4'b0001; wdt_timeout = 1'b1; ext_rst = 1'b1;
      tick();
      flags = '0; enables = '0; wdt_timeout = 1'b0; ext_rst = 1'b0;
      chk("R9 freeze off", int'(x_frz), 0);
      chk("R9 pd", int'(x_pd), 1);
      chk("R9 to kept", int'(x_to), 1);
      chk("R9 no wdt_clear", int'(x_wclr), 0);
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R9 no vector", int'(x_vec | x_frz), 0);
      end

      // R9 reset during start-up delay
      sleep_strobe = 1'b1;
      tick();
      sleep_strobe = 1'b0;
      wdt_timeout = 1'b1; gie = 1'b1;
      tick();
      wdt_timeout = 1'b0;
      chk("R4 to cleared", int'(x_to), 0);
      repeat (4) tick();
      chk("R6 still starting", int'(x_frz & r_frz), 1);
      ext_rst = 1'b1;
      tick();
      ext_rst = 1'b0;
      chk("R9 startup freeze off", int'(x_frz | r_frz), 0);
      chk("R9 startup to", int'(x_to), 1);
      chk("R9 startup pd", int'(x_pd), 1);
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R9 startup no vector", int'(x_vec | r_vec | x_frz), 0);
      end

      finish_run();
   end
endmodule